// File: doc/BRIEF.md
# Six-Step Commutation Sequencer with Gate Override Logic

This block steps a three-phase half bridge through the six conduction patterns of sensorless trapezoidal drive. A free-running commutation clock, asynchronous to the system clock, is resynchronised and each of its rising edges advances the pattern by one step. A synchronous align request parks the bridge in a dedicated alignment pattern that holds the rotor at a known angle before the first run step.

Every state also names which of the three phases is floating, so that external back-EMF sensing can sample it. Before the pattern reaches the gate pins, several overrides are applied in fixed precedence: undervoltage shuts everything off, brake closes all low-side switches, the PWM/current-limit enable chops only the low side, and an interlock keeps the phase-C low-side switch open until a feedback input confirms the phase-C high-side switch has turned off.

Top module: `bldc_six_step`

## Requirements
- R1: After rst_n is released, and one clock after align_req is sampled high, the block is in the alignment state: ls = 3'b010 (phase B low side on), hs_n = 3'b010 (phase A and C high sides on), sense_sel = 2'd0.
- R2: Each rising edge of comm_clk advances the state once: alignment goes to A, then A, B, C, D, E, F and back to A.
- R3: Bit 0, 1, 2 of ls and hs_n are phases A, B, C; with no override active the switches on are A: low C / high A, B: low C / high B, C: low A / high B, D: low A / high C, E: low B / high C, F: low B / high A. ls is active high, hs_n is active low.
- R4: A comm_clk rising edge is seen after two synchroniser flops and one edge flop: the new state shows at the outputs after the third system clock edge, and a level held high for any number of cycles advances the state only once.
- R5: sense_sel names the floating phase with 1 = A, 2 = B, 3 = C: B in A, A in B, C in C, B in D, A in E, C in F, and 0 in the alignment state.
- R6: With pwm_en low and no brake or undervoltage, ls is 3'b000 while hs_n keeps its commanded value.
- R7: With brake high and uv_fault low, hs_n = 3'b111 and ls = 3'b111 whatever pwm_en is.
- R8: With uv_fault high, hs_n = 3'b111 and ls = 3'b000, over brake and any state.
- R9: ls[2] is high only if hc_off_fb is high now and was high at the previous system clock edge.
- R10: align_req wins over a commutation step that arrives in the same cycle.
- R11: No phase ever has its low-side and high-side switches on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_req | input | 1 | Synchronous request to enter the alignment state |
| comm_clk | input | 1 | Asynchronous commutation clock; rising edge advances one step |
| pwm_en | input | 1 | PWM / current-limit enable for the low side |
| brake | input | 1 | Brake request, active high |
| uv_fault | input | 1 | Undervoltage lockout, active high |
| hc_off_fb | input | 1 | High when the phase-C high-side switch is confirmed off |
| hs_n | output | 3 | High-side gate drives, active low, bit 0 = phase A |
| ls | output | 3 | Low-side gate drives, active high, bit 0 = phase A |
| sense_sel | output | 2 | Floating phase to sample: 0 none, 1 A, 2 B, 3 C |

## Verification
The hardest situation to reach is the phase-C interlock at the alignment-to-A transition, where the low side of phase C is commanded on while the high side of the same phase is still considered conducting. The stimulus forces it by parking the block in the alignment state, pulling hc_off_fb low, stepping into A, and then releasing the feedback; the outputs are checked in the cycle of release and one edge later. A second hard case is a step pulse colliding with align_req, reached by raising comm_clk and align_req together and holding the request through the synchroniser latency.

// File: rtl/bldc_step_pkg.sv
package bldc_step_pkg;

  typedef enum logic [2:0] {
    ST_ALIGN = 3'd0,
    ST_A     = 3'd1,
    ST_B     = 3'd2,
    ST_C     = 3'd3,
    ST_D     = 3'd4,
    ST_E     = 3'd5,
    ST_F     = 3'd6
  } step_t;

  localparam int PHASES = 3;

  // successor in the run cycle; alignment leaves to A
  function automatic step_t step_next(input step_t s);
    case (s)
      ST_A:    step_next = ST_B;
      ST_B:    step_next = ST_C;
      ST_C:    step_next = ST_D;
      ST_D:    step_next = ST_E;
      ST_E:    step_next = ST_F;
      default: step_next = ST_A;
    endcase
  endfunction

  // low-side switches on, bit0 = phase A
  function automatic logic [PHASES-1:0] low_mask(input step_t s);
    case (s)
      ST_A, ST_B: low_mask = 3'b100;
      ST_C, ST_D: low_mask = 3'b001;
      ST_E, ST_F: low_mask = 3'b010;
      default:    low_mask = 3'b010;
    endcase
  endfunction

  // high-side switches on (positive logic), bit0 = phase A
  function automatic logic [PHASES-1:0] high_mask(input step_t s);
    case (s)
      ST_A, ST_F: high_mask = 3'b001;
      ST_B, ST_C: high_mask = 3'b010;
      ST_D, ST_E: high_mask = 3'b100;
      default:    high_mask = 3'b101;
    endcase
  endfunction

  // floating phase code: 0 none, 1 A, 2 B, 3 C
  function automatic logic [1:0] float_code(input step_t s);
    case (s)
      ST_A, ST_D: float_code = 2'd2;
      ST_B, ST_E: float_code = 2'd1;
      ST_C, ST_F: float_code = 2'd3;
      default:    float_code = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bldc_edge_sync.sv
module bldc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_in;
  end

  for (genvar g = 1; g <= LAST; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign rise_pulse = chain[LAST-1] & ~chain[LAST];

  // R4: one pulse per rising edge, never two in a row
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/bldc_step_seq.sv
module bldc_step_seq
  import bldc_step_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  align_req,
  input  logic  step,
  output step_t state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state <= ST_ALIGN;
    else if (align_req) state <= ST_ALIGN;
    else if (step)      state <= step_next(state);
  end

  // R1 / R10: align request wins, even over a step pulse
  p_align_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    align_req |=> state == ST_ALIGN);

  // R4: no step, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !align_req) |=> $stable(state));

  // R2: a step always moves and never lands in alignment
  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !align_req) |=> (state != $past(state)) && (state != ST_ALIGN));

endmodule

// File: rtl/bldc_lc_interlock.sv
module bldc_lc_interlock #(
  parameter int CONFIRM_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hc_off_fb,
  output logic lc_allow
);
  localparam int CW = $clog2(CONFIRM_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(CONFIRM_CYCLES);

  logic [CW-1:0] seen_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               seen_cnt <= '0;
    else if (!hc_off_fb)      seen_cnt <= '0;
    else if (seen_cnt < CMAX) seen_cnt <= seen_cnt + 1'b1;
  end

  assign lc_allow = hc_off_fb && (seen_cnt >= CMAX);

endmodule

// File: rtl/bldc_gate_mux.sv
module bldc_gate_mux
  import bldc_step_pkg::*;
(
  input  step_t       state,
  input  logic        pwm_en,
  input  logic        brake,
  input  logic        uv_fault,
  input  logic        lc_allow,
  output logic [2:0]  hs_n,
  output logic [2:0]  ls
);
  logic [2:0] lo_cmd, hi_cmd, lo_pre, hi_on;

  assign lo_cmd = low_mask(state);
  assign hi_cmd = high_mask(state);

  // precedence: undervoltage, then brake, then commutation with chopping
  always_comb begin
    if (uv_fault) begin
      lo_pre = 3'b000;
      hi_on  = 3'b000;
    end else if (brake) begin
      lo_pre = 3'b111;
      hi_on  = 3'b000;
    end else begin
      lo_pre = lo_cmd & {3{pwm_en}};
      hi_on  = hi_cmd;
    end
  end

  assign ls   = {lo_pre[2] & lc_allow, lo_pre[1:0]};
  assign hs_n = ~hi_on;

endmodule

// File: rtl/bldc_six_step.sv
module bldc_six_step
  import bldc_step_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int CONFIRM_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       align_req,
  input  logic       comm_clk,
  input  logic       pwm_en,
  input  logic       brake,
  input  logic       uv_fault,
  input  logic       hc_off_fb,
  output logic [2:0] hs_n,
  output logic [2:0] ls,
  output logic [1:0] sense_sel
);

  logic  step_evt;
  logic  lc_allow;
  step_t cur_state;

  bldc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (comm_clk),
    .rise_pulse (step_evt)
  );

  bldc_step_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .align_req (align_req),
    .step      (step_evt),
    .state     (cur_state)
  );

  bldc_lc_interlock #(.CONFIRM_CYCLES(CONFIRM_CYCLES)) u_ilk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hc_off_fb (hc_off_fb),
    .lc_allow  (lc_allow)
  );

  bldc_gate_mux u_mux (
    .state    (cur_state),
    .pwm_en   (pwm_en),
    .brake    (brake),
    .uv_fault (uv_fault),
    .lc_allow (lc_allow),
    .hs_n     (hs_n),
    .ls       (ls)
  );

  assign sense_sel = float_code(cur_state);

  // R8: undervoltage forces every switch off
  p_uv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault |-> (hs_n == 3'b111) && (ls == 3'b000));

  // R7: brake keeps all high sides off
  p_brake_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (brake && !uv_fault) |-> hs_n == 3'b111);

  // R9: phase-C low side needs confirmation from this and the previous edge
  p_lc_confirm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ls[2] |-> (hc_off_fb && $past(hc_off_fb)));

  // R11: no phase conducts through both switches
  p_no_shoot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ls & ~hs_n) == 3'b000);

  // R5: nothing is sampled exactly while in alignment
  p_sense_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_sel == 2'd0) == (cur_state == ST_ALIGN));

endmodule

// File: tb/test_bldc_six_step.sv
`timescale 1ns/1ps
module test_bldc_six_step;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic align_req = 1'b0, comm_clk = 1'b0, pwm_en = 1'b1;
  logic brake = 1'b0, uv_fault = 1'b0, hc_off_fb = 1'b1;
  logic [2:0] hs_n, ls;
  logic [1:0] sense_sel;

  int n_cmp = 0;
  int n_bad = 0;
  int pos = 0; // model: 0 = alignment, 1..6 = A..F

  always #2.5 clk = ~clk;

  bldc_six_step i_bldc_six_step (
    .clk(clk), .rst_n(rst_n), .align_req(align_req), .comm_clk(comm_clk),
    .pwm_en(pwm_en), .brake(brake), .uv_fault(uv_fault), .hc_off_fb(hc_off_fb),
    .hs_n(hs_n), .ls(ls), .sense_sel(sense_sel)
  );

  // expected drives written as phase lists per requirement
  function automatic logic [2:0] want_ls(input int p);
    logic [2:0] m = 3'b000;
    if (p == 3 || p == 4) m[0] = 1'b1;
    if (p == 0 || p == 5 || p == 6) m[1] = 1'b1;
    if (p == 1 || p == 2) m[2] = 1'b1;
    return m;
  endfunction

  function automatic logic [2:0] want_hs_n(input int p);
    logic [2:0] m = 3'b111;
    if (p == 0 || p == 1 || p == 6) m[0] = 1'b0;
    if (p == 2 || p == 3) m[1] = 1'b0;
    if (p == 0 || p == 4 || p == 5) m[2] = 1'b0;
    return m;
  endfunction

  function automatic logic [1:0] want_sel(input int p);
    int ph;
    if (p == 0) return 2'd0;
    ph = (p == 2 || p == 5) ? 1 : (p == 1 || p == 4) ? 2 : 3;
    return 2'(ph);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_pos(input string req);
    check({req, " ls"}, 8'(ls), 8'(want_ls(pos)));
    check({req, " hs_n"}, 8'(hs_n), 8'(want_hs_n(pos)));
    check({req, " sense_sel"}, 8'(sense_sel), 8'(want_sel(pos)));
    check("R11 overlap", 8'(ls & ~hs_n), 8'h0);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_step();
    comm_clk = 1'b1;
    wait_n(4);
    comm_clk = 1'b0;
    wait_n(4);
    pos = (pos == 6) ? 1 : pos + 1;
  endtask

  task automatic do_align();
    align_req = 1'b1;
    wait_n(1);
    align_req = 1'b0;
    pos = 0;
  endtask

  task automatic t_reset();
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    check_pos("R1 reset");
  endtask

  task automatic t_walk();
    for (int k = 0; k < 7; k++) begin
      do_step();
      check_pos("R2 R3 R5 walk");
    end
    do_align();
    check_pos("R1 align_req");
  endtask

  task automatic t_hold();
    do_step();               // now A
    comm_clk = 1'b1;
    wait_n(2);               // two edges: still old state
    check("R4 latency early", 8'(sense_sel), 8'(want_sel(pos)));
    wait_n(1);               // third edge: advanced
    pos = pos + 1;
    check("R4 latency on time", 8'(sense_sel), 8'(want_sel(pos)));
    wait_n(20);
    check_pos("R4 held high one step");
    comm_clk = 1'b0;
    wait_n(4);
    check_pos("R4 after release");
  endtask

  task automatic t_pwm();
    pwm_en = 1'b0;
    wait_n(1);
    check("R6 ls chopped", 8'(ls), 8'h0);
    check("R6 hs kept", 8'(hs_n), 8'(want_hs_n(pos)));
    do_step();
    check("R6 ls chopped next", 8'(ls), 8'h0);
    check("R6 sense unaffected", 8'(sense_sel), 8'(want_sel(pos)));
    pwm_en = 1'b1;
    wait_n(1);
    check_pos("R6 restored");
  endtask

  task automatic t_brake();
    brake = 1'b1;
    pwm_en = 1'b0;
    wait_n(1);
    check("R7 brake ls", 8'(ls), 8'h7);
    check("R7 brake hs_n", 8'(hs_n), 8'h7);
    pwm_en = 1'b1;
    wait_n(1);
    check("R7 brake ls pwm on", 8'(ls), 8'h7);
    brake = 1'b0;
    wait_n(1);
    check_pos("R7 released");
  endtask

  task automatic t_uv();
    uv_fault = 1'b1;
    brake = 1'b1;
    wait_n(1);
    check("R8 uv over brake ls", 8'(ls), 8'h0);
    check("R8 uv over brake hs_n", 8'(hs_n), 8'h7);
    brake = 1'b0;
    do_align();
    check("R8 uv in align ls", 8'(ls), 8'h0);
    check("R8 uv in align hs_n", 8'(hs_n), 8'h7);
    uv_fault = 1'b0;
    wait_n(1);
    check_pos("R8 released");
  endtask

  task automatic t_interlock();
    hc_off_fb = 1'b0;
    wait_n(1);
    do_step();               // alignment -> A, LC commanded
    check("R9 lc blocked", 8'(ls), 8'h0);
    check("R9 hs in A", 8'(hs_n), 8'(want_hs_n(pos)));
    hc_off_fb = 1'b1;
    #0.5;
    check("R9 lc same cycle", 8'(ls), 8'h0);
    wait_n(1);
    check("R9 lc released", 8'(ls), 8'h4);
  endtask

  task automatic t_race();
    do_step();               // A -> B
    comm_clk = 1'b1;
    align_req = 1'b1;
    wait_n(5);               // step pulse falls inside this window
    align_req = 1'b0;
    pos = 0;
    check_pos("R10 align over step");
    comm_clk = 1'b0;
    wait_n(4);
    check_pos("R10 no late step");
  endtask

  initial begin : watchdog
    #500us;
    n_bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_walk();
    t_hold();
    t_pwm();
    t_brake();
    t_uv();
    t_interlock();
    t_race();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule